// File: doc/BRIEF.md
# One-Wire ROM Search Accelerator

This block runs the bit-by-bit device-ID search of a one-wire bus master in hardware. While search mode is enabled, each byte that software writes to the data port becomes four search steps. A step has three bus slots. The first two are read slots that sample an ID bit and then its complement. The third is a write slot that sends back the resolved direction, so that devices whose ID does not match drop out of the search.

Every written byte carries four preferred directions, one for each step. The byte returned through the receive buffer packs the four resolved path bits interleaved with four discrepancy flags. Sixteen exchanges cover a 64-bit ID, lowest bits first. Software uses the discrepancy flags to pick the next path. Bus reset and the search command byte are handled outside this block. The block does not generate bus timing either: it asks for one slot at a time on a slot request/done interface.

Completion of each exchange sets the same receive-full flag and interrupt that a plain byte read uses. The flag is cleared when the received byte is read.

Top module: `rom_search_accel`

## Requirements
- R1: Exchanges start only while `searchEn` is 1. A byte written while it is 0 causes no slot and no reply. Dropping `searchEn` in the middle of an exchange abandons it: no reply is produced, and no new slot is requested from the cycle after the drop onward.
- R2: In a written byte, the preferred direction for step k (k = 0..3, step 0 first) is byte bit 2k+1. The even bits are ignored.
- R3: Each step issues exactly three slots in this order: read ID bit, read complement, write. Only one slot is outstanding at a time, and `slotReq` is a single-cycle pulse. An exchange therefore uses exactly 12 slots.
- R4: If the two read values differ, the path bit is the first read value and the discrepancy flag is 0.
- R5: If both read values are 0, the path bit is the preferred bit and the discrepancy flag is 1.
- R6: If both read values are 1 (no device responding), the path bit is 1 and the discrepancy flag is 1.
- R7: The write slot of a step sends that step's path bit on `slotWrBit`, with `slotWrite`=1. Read slots have `slotWrite`=0.
- R8: In the reply byte, the path bit of step k is bit 2k+1 and its discrepancy flag is bit 2k.
- R9: When the last write slot of an exchange completes, `rxData` takes the reply and `rxFull` goes to 1 in the next cycle. `irq` equals `rxFull` AND `irqEn`. A pulse on `rdAck` clears `rxFull`. If a completion and `rdAck` fall in the same cycle, the completion wins.
- R10: A byte written while an exchange is in progress is ignored. The reply and the slot count are those of the first byte alone.
- R11: The block counts exchanges modulo 16, starting from the first exchange after `searchEn` rises. If the 16th exchange ends with both the path bit and the discrepancy flag of step 3 set (ID bit 63), `searchErr` goes to 1. While `searchEn` is 0, the count and `searchErr` are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| searchEn | input | 1 | Search mode enable |
| irqEn | input | 1 | Receive-full interrupt enable |
| wrValid | input | 1 | Data-port write strobe |
| wrData | input | 8 | Byte of preferred directions |
| rdAck | input | 1 | Data-port read strobe; clears the receive-full flag |
| rxData | output | 8 | Reply byte with path and discrepancy bits |
| rxFull | output | 1 | Receive buffer full |
| irq | output | 1 | Interrupt request |
| searchErr | output | 1 | Bus error flagged at ID bit 63 |
| slotReq | output | 1 | Single-cycle request for one bus slot |
| slotWrite | output | 1 | The requested slot is a write slot (1) or a read slot (0) |
| slotWrBit | output | 1 | Bit to send in a write slot |
| slotDone | input | 1 | The requested slot has completed |
| slotRdBit | input | 1 | Bus value sampled in a read slot, valid with slotDone |

## Verification
The main function is tried with three device populations. A bus with three devices whose IDs diverge at several bit positions is searched in full, which exercises the differ, both-zero and preferred-direction cases, and drop-out after each write slot. An empty bus returns all-ones reads; this tells the both-one case apart from a real discrepancy and raises the bit-63 error. Single writes are also placed against a disabled engine, against a busy engine, and against a mid-exchange disable, which separates ignored, queued and abandoned requests by the slot count and the receive flag.

// File: rtl/rom_search_accel_pkg.sv
package rom_search_accel_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } ctrlState_e;

  typedef enum logic [1:0] {
    PH_TRUE  = 2'd0,
    PH_COMP  = 2'd1,
    PH_WRITE = 2'd2
  } slotPhase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadTx;
    logic capTrue;
    logic resolve;
    logic finish;
    logic abort;
  } dpStrobe_t;

endpackage

// File: rtl/rom_search_accel_ctrl.sv
module rom_search_accel_ctrl
  import rom_search_accel_pkg::*;
#(
  parameter int STEPS = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             searchEn,
  input  logic             wrValid,
  input  logic             slotDone,
  output dpStrobe_t        strobe,
  output logic [IDX_W-1:0] bitIdx,
  output logic             slotReq,
  output logic             slotWrite
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(STEPS - 1);

  ctrlState_e state, stateNext;
  slotPhase_e phase, phaseNext;
  logic [IDX_W-1:0] idxNext;

  always_comb begin
    stateNext = state;
    phaseNext = phase;
    idxNext   = bitIdx;
    strobe    = '0;
    if (!searchEn) begin
      strobe.abort = 1'b1;
      stateNext    = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (wrValid) begin
            strobe.loadTx = 1'b1;
            idxNext       = '0;
            phaseNext     = PH_TRUE;
            stateNext     = ST_REQ;
          end
        end
        ST_REQ: stateNext = ST_WAIT;
        ST_WAIT: begin
          if (slotDone) begin
            unique case (phase)
              PH_TRUE: begin
                strobe.capTrue = 1'b1;
                phaseNext      = PH_COMP;
                stateNext      = ST_REQ;
              end
              PH_COMP: begin
                strobe.resolve = 1'b1;
                phaseNext      = PH_WRITE;
                stateNext      = ST_REQ;
              end
              default: begin
                if (bitIdx == LAST_IDX) begin
                  strobe.finish = 1'b1;
                  stateNext     = ST_IDLE;
                end else begin
                  idxNext   = bitIdx + 1'b1;
                  phaseNext = PH_TRUE;
                  stateNext = ST_REQ;
                end
              end
            endcase
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      phase  <= PH_TRUE;
      bitIdx <= '0;
    end else begin
      state  <= stateNext;
      phase  <= phaseNext;
      bitIdx <= idxNext;
    end
  end

  assign slotReq   = (state == ST_REQ) && searchEn;
  assign slotWrite = (phase == PH_WRITE);

endmodule

// File: rtl/rom_search_accel_dpath.sv
module rom_search_accel_dpath
  import rom_search_accel_pkg::*;
#(
  parameter int STEPS  = 4,
  parameter int IDX_W  = 2,
  parameter int BYTE_W = 8,
  parameter int XCHG   = 16,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              slotRdBit,
  input  logic              irqEn,
  input  logic              rdAck,
  output logic [BYTE_W-1:0] rxData,
  output logic              rxFull,
  output logic              irq,
  output logic              searchErr,
  output logic              slotWrBit
);

  localparam logic [CNT_W-1:0] LAST_XCHG = CNT_W'(XCHG - 1);

  logic [BYTE_W-1:0] txReg;
  logic              trueBit;
  logic [STEPS-1:0]  pathVec;
  logic [STEPS-1:0]  discVec;
  logic [CNT_W-1:0]  nibbleCnt;
  logic [BYTE_W-1:0] packed_reply;
  logic              prefBit;
  logic              newPath;
  logic              newDisc;

  // odd byte bits hold the preferred direction of each step
  assign prefBit = txReg[{bitIdx, 1'b1}];

  always_comb begin
    if (trueBit != slotRdBit) begin
      newPath = trueBit;
      newDisc = 1'b0;
    end else if (trueBit) begin
      newPath = 1'b1;
      newDisc = 1'b1;
    end else begin
      newPath = prefBit;
      newDisc = 1'b1;
    end
  end

  for (genvar k = 0; k < STEPS; k++) begin : g_pack
    assign packed_reply[2*k+1] = pathVec[k];
    assign packed_reply[2*k]   = discVec[k];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txReg   <= '0;
      trueBit <= 1'b0;
      pathVec <= '0;
      discVec <= '0;
    end else begin
      if (strobe.loadTx) begin
        txReg   <= wrData;
        pathVec <= '0;
        discVec <= '0;
      end
      if (strobe.capTrue) trueBit <= slotRdBit;
      if (strobe.resolve) begin
        pathVec[bitIdx] <= newPath;
        discVec[bitIdx] <= newDisc;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData <= '0;
      rxFull <= 1'b0;
    end else if (strobe.finish) begin
      rxData <= packed_reply;
      rxFull <= 1'b1;
    end else if (rdAck) begin
      rxFull <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nibbleCnt <= '0;
      searchErr <= 1'b0;
    end else if (strobe.abort) begin
      nibbleCnt <= '0;
      searchErr <= 1'b0;
    end else if (strobe.finish) begin
      nibbleCnt <= nibbleCnt + 1'b1;
      if (nibbleCnt == LAST_XCHG && pathVec[STEPS-1] && discVec[STEPS-1])
        searchErr <= 1'b1;
    end
  end

  assign irq       = rxFull & irqEn;
  assign slotWrBit = pathVec[bitIdx];

endmodule

// File: rtl/rom_search_accel.sv
module rom_search_accel
  import rom_search_accel_pkg::*;
#(
  parameter int STEPS   = 4,
  parameter int ID_BITS = 64
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         searchEn,
  input  logic         irqEn,
  input  logic         wrValid,
  input  logic [7:0]   wrData,
  input  logic         rdAck,
  output logic [7:0]   rxData,
  output logic         rxFull,
  output logic         irq,
  output logic         searchErr,
  output logic         slotReq,
  output logic         slotWrite,
  output logic         slotWrBit,
  input  logic         slotDone,
  input  logic         slotRdBit
);

  localparam int BYTE_W = 2 * STEPS;
  localparam int XCHG   = ID_BITS / STEPS;
  localparam int IDX_W  = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam int CNT_W  = (XCHG > 1) ? $clog2(XCHG) : 1;

  dpStrobe_t        strobe;
  logic [IDX_W-1:0] bitIdx;

  rom_search_accel_ctrl #(
    .STEPS(STEPS),
    .IDX_W(IDX_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .searchEn (searchEn),
    .wrValid  (wrValid),
    .slotDone (slotDone),
    .strobe   (strobe),
    .bitIdx   (bitIdx),
    .slotReq  (slotReq),
    .slotWrite(slotWrite)
  );

  rom_search_accel_dpath #(
    .STEPS (STEPS),
    .IDX_W (IDX_W),
    .BYTE_W(BYTE_W),
    .XCHG  (XCHG),
    .CNT_W (CNT_W)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .bitIdx   (bitIdx),
    .wrData   (wrData[BYTE_W-1:0]),
    .slotRdBit(slotRdBit),
    .irqEn    (irqEn),
    .rdAck    (rdAck),
    .rxData   (rxData[BYTE_W-1:0]),
    .rxFull   (rxFull),
    .irq      (irq),
    .searchErr(searchErr),
    .slotWrBit(slotWrBit)
  );

endmodule

// File: rtl/rom_search_accel_chk.sv
module rom_search_accel_chk (
  input logic clk,
  input logic rstN,
  input logic searchEn,
  input logic irqEn,
  input logic slotReq,
  input logic slotDone,
  input logic rxFull,
  input logic irq,
  input logic searchErr
);

  // R3
  slot_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    slotReq |=> !slotReq);

  // R1
  no_slot_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !searchEn |=> !slotReq);

  // R9
  irq_needs_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (rxFull && irqEn));

  // R9
  full_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFull) |-> $past(slotDone));

  // R11
  err_only_enabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(searchErr) |-> $past(searchEn));

endmodule

bind rom_search_accel rom_search_accel_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .searchEn (searchEn),
  .irqEn    (irqEn),
  .slotReq  (slotReq),
  .slotDone (slotDone),
  .rxFull   (rxFull),
  .irq      (irq),
  .searchErr(searchErr)
);

// File: tb/rom_search_accel_bench.sv
module rom_search_accel_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 3;
  localparam int LAT = 3;
  localparam logic [63:0] IDS [NS] = '{
    64'h0000_0000_0000_00A5,
    64'h8000_0000_0000_00A1,
    64'h1234_5678_9ABC_DEF0
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic searchEn = 1'b0, irqEn = 1'b0, wrValid = 1'b0, rdAck = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rxData;
  logic rxFull, irq, searchErr, slotReq, slotWrite, slotWrBit;
  logic slotDone, slotRdBit;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rom_search_accel u_rom_search_accel (
    .clk(clk), .rstN(rstN), .searchEn(searchEn), .irqEn(irqEn),
    .wrValid(wrValid), .wrData(wrData), .rdAck(rdAck),
    .rxData(rxData), .rxFull(rxFull), .irq(irq), .searchErr(searchErr),
    .slotReq(slotReq), .slotWrite(slotWrite), .slotWrBit(slotWrBit),
    .slotDone(slotDone), .slotRdBit(slotRdBit)
  );

  // ---------------- bus model: wired-AND of the active devices -------------
  logic busRst = 1'b0;
  logic [NS-1:0] slaveMask = '1;
  logic [NS-1:0] active;
  int slotPos, seqCnt, busyCnt, reqCount, orderErr;
  logic pendWrite, pendBit;

  always @(posedge clk) begin
    if (!rstN) begin
      slotDone <= 1'b0; slotRdBit <= 1'b0; busyCnt <= 0;
      active <= '1; slotPos <= 0; seqCnt <= 0; reqCount <= 0; orderErr <= 0;
      pendWrite <= 1'b0; pendBit <= 1'b0;
    end else begin
      slotDone <= 1'b0;
      if (busRst) begin
        active <= slaveMask; slotPos <= 0; seqCnt <= 0; busyCnt <= 0;
      end else if (slotReq) begin
        reqCount <= reqCount + 1;
        if (busyCnt != 0) orderErr <= orderErr + 1;
        if (slotWrite != (seqCnt % 3 == 2)) orderErr <= orderErr + 1;
        pendWrite <= slotWrite; pendBit <= slotWrBit; busyCnt <= LAT;
      end else if (busyCnt != 0) begin
        busyCnt <= busyCnt - 1;
        if (busyCnt == 1) begin
          logic v;
          slotDone <= 1'b1;
          v = 1'b1;
          for (int s = 0; s < NS; s++)
            if (active[s]) v &= (seqCnt % 3 == 0) ? IDS[s][slotPos] : ~IDS[s][slotPos];
          slotRdBit <= v;
          if (pendWrite) begin
            for (int s = 0; s < NS; s++)
              if (IDS[s][slotPos] != pendBit) active[s] <= 1'b0;
            slotPos <= slotPos + 1;
          end
          seqCnt <= seqCnt + 1;
        end
      end
    end
  end

  // ---------------- expected values from the requirements ------------------
  function automatic logic [7:0] expReply(input logic [7:0] w, input int nib,
                                          inout logic [NS-1:0] act);
    logic [7:0] r;
    r = '0;
    for (int k = 0; k < 4; k++) begin
      int g;
      logic t, c, p, d;
      g = nib * 4 + k;
      t = 1'b1; c = 1'b1;
      for (int s = 0; s < NS; s++)
        if (act[s]) begin t &= IDS[s][g]; c &= ~IDS[s][g]; end
      if (t != c) begin p = t; d = 1'b0; end        // R4
      else if (t) begin p = 1'b1; d = 1'b1; end     // R6
      else begin p = w[2*k+1]; d = 1'b1; end        // R5, R2
      for (int s = 0; s < NS; s++)
        if (act[s] && IDS[s][g] != p) act[s] = 1'b0; // R7
      r[2*k+1] = p; r[2*k] = d;                     // R8
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulseBusRst();
    @(negedge clk) busRst = 1'b1;
    @(negedge clk) busRst = 1'b0;
  endtask

  task automatic writeByte(input logic [7:0] w);
    @(negedge clk) wrValid = 1'b1; wrData = w;
    @(negedge clk) wrValid = 1'b0;
  endtask

  task automatic readByte(output logic [7:0] r);
    while (!rxFull) @(negedge clk);
    r = rxData;
    rdAck = 1'b1;
    @(negedge clk) rdAck = 1'b0;
  endtask

  task automatic xchg(input logic [7:0] w, output logic [7:0] r);
    writeByte(w);
    readByte(r);
  endtask

  // ---------------- stimulus ----------------------------------------------
  initial begin : main
    logic [7:0] rep, expv, w;
    logic [NS-1:0] act;
    logic [63:0] r, rp, dv;
    logic [NS-1:0] found;
    int base;

    repeat (3) @(negedge clk);
    check(rxFull == 0 && irq == 0 && slotReq == 0 && searchErr == 0, "R9 reset",
          {rxFull, irq, slotReq, searchErr}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: write while disabled is ignored
    base = reqCount;
    writeByte(8'hAA);
    repeat (30) @(negedge clk);
    check(reqCount == base && rxFull == 0, "R1 disabled write", reqCount - base, 0);

    // full search over three devices
    searchEn = 1'b1;
    irqEn = 1'b1;
    r = '0; found = '0;
    for (int pass = 0; pass < 6; pass++) begin
      int msb;
      pulseBusRst();
      act = slaveMask;
      rp = '0; dv = '0;
      for (int nib = 0; nib < 16; nib++) begin
        w = '0;
        for (int k = 0; k < 4; k++) w[2*k+1] = r[nib*4+k];
        expv = expReply(w, nib, act);
        writeByte(w);
        while (!rxFull) @(negedge clk);
        check(irq == 1'b1, "R9 irq with enable", irq, 1);
        readByte(rep);
        check(rep == expv, "R4 R5 R6 R8 reply", rep, expv);
        check(rxFull == 0, "R9 read clears", rxFull, 0);
        for (int k = 0; k < 4; k++) begin
          rp[nib*4+k] = rep[2*k+1];
          dv[nib*4+k] = rep[2*k];
        end
      end
      check(searchErr == 0, "R11 no error on good pass", searchErr, 0);
      begin
        bit hit;
        hit = 0;
        for (int s = 0; s < NS; s++)
          if (rp == IDS[s] && !found[s]) begin found[s] = 1'b1; hit = 1; end
        check(hit, "R7 found new id", rp, 0);
      end
      dv &= ~r;
      if (dv == '0) break;
      msb = 0;
      for (int b = 0; b < 64; b++) if (dv[b]) msb = b;
      r = (r & ((64'd1 << msb) - 64'd1)) | (64'd1 << msb);
    end
    check(found == '1, "R5 all ids found", found, 3'b111);
    check(orderErr == 0, "R3 slot order", orderErr, 0);

    // R9: interrupt masked
    irqEn = 1'b0;
    pulseBusRst();
    writeByte(8'h00);
    while (!rxFull) @(negedge clk);
    check(irq == 0, "R9 irq masked", irq, 0);
    readByte(rep);
    searchEn = 1'b0;
    @(negedge clk);
    searchEn = 1'b1;

    // R10: write while busy is ignored
    pulseBusRst();
    act = slaveMask;
    expv = expReply(8'h00, 0, act);
    base = reqCount;
    writeByte(8'h00);
    repeat (3) @(negedge clk);
    writeByte(8'hFF);
    readByte(rep);
    repeat (30) @(negedge clk);
    check(rep == expv, "R10 busy write reply", rep, expv);
    check(reqCount - base == 12, "R10 R3 slot count", reqCount - base, 12);
    check(rxFull == 0, "R10 no second reply", rxFull, 0);

    // R1: abort mid-exchange
    pulseBusRst();
    writeByte(8'h00);
    repeat (6) @(negedge clk);
    searchEn = 1'b0;
    @(negedge clk);
    base = reqCount;
    repeat (40) @(negedge clk);
    check(reqCount == base && rxFull == 0, "R1 abort", {reqCount - base, rxFull}, 0);
    searchEn = 1'b1;

    // R6, R11: empty bus
    slaveMask = '0;
    pulseBusRst();
    for (int nib = 0; nib < 16; nib++) begin
      xchg(8'h00, rep);
      check(rep == 8'hFF, "R6 empty bus reply", rep, 8'hFF);
      if (nib == 14) check(searchErr == 0, "R11 not before 16th", searchErr, 0);
    end
    @(negedge clk);
    check(searchErr == 1, "R11 bit63 error", searchErr, 1);
    searchEn = 1'b0;
    repeat (2) @(negedge clk);
    check(searchErr == 0, "R11 cleared when off", searchErr, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R3 actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule